// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits behind the receive byte path of an Ethernet MAC and decides, frame by frame, whether the frame should be kept. The destination address arrives one octet per valid strobe, in wire order. A marker on the first octet starts a new address. Once all six octets are in, the block compares the address against four things: a programmable station address, the broadcast address, a four-entry table of 24-bit multicast prefixes, and two mode bits (promiscuous and all-multicast). It then presents a one-cycle done strobe together with an accept flag.

Software programs the station address, the prefix table and the mode bits through a simple write port. Each write selects a register with a small address and takes a 32-bit data word. Multicast table matching looks only at the first three octets of the destination. A table entry holding zero is treated as empty.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, `dec_done` and `dec_accept` are low, and the station address, mode bits and all table entries are zero. With a zero station address, a destination of all zeros is therefore accepted.
- R2: An address starts with an octet presented with `da_valid` and `da_first` both high. The following five octets come on later cycles with `da_valid` high and `da_first` low, and idle cycles may fall between them. `dec_done` is high for exactly the one cycle after the clock edge that takes the sixth octet. Further octets are ignored until the next first marker, and a first marker in mid-address restarts the count.
- R3: The register writes use these selects: 0 is station high, 1 is station low, 2 is mode, and 4+n is table entry n (select 3 is ignored). Station high bits 15:8 hold octet 0 and bits 7:0 hold octet 1. Station low bits 31:24, 23:16, 15:8 and 7:0 hold octets 2, 3, 4 and 5. A destination equal to the station address is accepted.
- R4: A destination of all ones (broadcast) is always accepted.
- R5: When mode bit 0 (promiscuous) is set, every destination is accepted.
- R6: When mode bit 1 (all-multicast) is set, every destination with the group bit (bit 0 of octet 0) set is accepted. A non-group destination gains nothing from this bit.
- R7: A group destination is accepted when its octets 0, 1 and 2 equal a nonzero table entry packed with octet 0 in bits 7:0, octet 1 in bits 15:8 and octet 2 in bits 23:16. Octets 3 to 5 play no part in this match.
- R8: A table entry equal to zero never matches any destination.
- R9: A destination that meets none of the conditions in R3 to R7 is rejected (`dec_accept` low while `dec_done` is high).
- R10: `dec_accept` is low on every cycle where `dec_done` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| da_valid | input | 1 | Destination octet valid |
| da_first | input | 1 | Marks octet 0 of a destination |
| da_byte | input | 8 | Destination octet, wire order |
| dec_done | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame accepted, valid with dec_done |

## Verification
The decision is the block's only timed result. It is due on the cycle right after the edge that takes the sixth octet, and it drops one cycle later. Each scenario task drives octets on falling edges and samples on the falling edge straight after the sixth octet's rising edge, where it expects `dec_done` high with the computed accept value. It then samples one cycle later and expects both outputs low. Register writes take effect at the edge that follows the write cycle, so every write finishes before the next address begins. Timing scenarios add extra trailing octets, idle gaps and a mid-address restart, and check that `dec_done` comes only where the octet count says.

// File: rtl/rdf_pkg.sv
package rdf_pkg;

  localparam int ADDR_OCTETS   = 6;
  localparam int ADDR_W        = 8 * ADDR_OCTETS;
  localparam int PREFIX_OCTETS = 3;
  localparam int PREFIX_W      = 8 * PREFIX_OCTETS;

  typedef struct packed {
    logic allmulti;
    logic promisc;
  } mode_t;

  // Station registers to a wire-order address (octet 0 in the top byte).
  function automatic logic [ADDR_W-1:0] station_from_regs(
      input logic [15:0] hi, input logic [31:0] lo);
    return {hi, lo};
  endfunction

  // Table entry (octet 0 in the low byte) to a wire-order prefix.
  function automatic logic [PREFIX_W-1:0] prefix_from_entry(
      input logic [PREFIX_W-1:0] e);
    return {e[7:0], e[15:8], e[23:16]};
  endfunction

  function automatic logic group_bit(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-8];
  endfunction

  function automatic logic all_ones(input logic [ADDR_W-1:0] a);
    return &a;
  endfunction

endpackage

// File: rtl/rdf_collect.sv
module rdf_collect #(
  parameter int OCTETS = 6,
  localparam int CNT_W = $clog2(OCTETS + 1),
  localparam int AW    = 8 * OCTETS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          da_valid,
  input  logic          da_first,
  input  logic [7:0]    da_byte,
  output logic [AW-1:0] addr_full,
  output logic          last_byte
);

  logic [7:0]       held [OCTETS-1];
  logic [CNT_W-1:0] cnt;

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OCTETS - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(OCTETS);

  logic take_mid;
  assign take_mid  = da_valid && !da_first && cnt != '0 && cnt != CNT_FULL;
  assign last_byte = take_mid && cnt == CNT_LAST;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (da_valid && da_first) begin
      cnt <= CNT_W'(1);
    end else if (take_mid) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  for (genvar i = 0; i < OCTETS - 1; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        held[i] <= '0;
      end else if (i == 0 && da_valid && da_first) begin
        held[i] <= da_byte;
      end else if (i != 0 && take_mid && cnt == CNT_W'(i)) begin
        held[i] <= da_byte;
      end
    end
    assign addr_full[AW-1-8*i -: 8] = held[i];
  end

  assign addr_full[7:0] = da_byte;

endmodule

// File: rtl/rdf_cfg.sv
module rdf_cfg
  import rdf_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int SEL_W   = 3,
  localparam int TBL_BASE = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [SEL_W-1:0]            cfg_sel,
  input  logic [31:0]                 cfg_wdata,
  output logic [15:0]                 station_hi,
  output logic [31:0]                 station_lo,
  output mode_t                       mode,
  output logic [ENTRIES*PREFIX_W-1:0] tbl
);

  localparam logic [SEL_W-1:0] SEL_HI   = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_LO   = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_MODE = SEL_W'(2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      station_hi <= '0;
      station_lo <= '0;
      mode       <= '0;
    end else if (cfg_we) begin
      if (cfg_sel == SEL_HI)   station_hi <= cfg_wdata[15:0];
      if (cfg_sel == SEL_LO)   station_lo <= cfg_wdata;
      if (cfg_sel == SEL_MODE) mode       <= mode_t'(cfg_wdata[1:0]);
    end
  end

  for (genvar n = 0; n < ENTRIES; n++) begin : g_entry
    localparam logic [SEL_W-1:0] SEL_N = SEL_W'(TBL_BASE + n);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tbl[n*PREFIX_W +: PREFIX_W] <= '0;
      end else if (cfg_we && cfg_sel == SEL_N) begin
        tbl[n*PREFIX_W +: PREFIX_W] <= cfg_wdata[PREFIX_W-1:0];
      end
    end
  end

endmodule

// File: rtl/rdf_match.sv
module rdf_match
  import rdf_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic [15:0]                 station_hi,
  input  logic [31:0]                 station_lo,
  input  mode_t                       mode,
  input  logic [ENTRIES*PREFIX_W-1:0] tbl,
  output logic                        station_hit,
  output logic                        bcast_hit,
  output logic                        group_hit,
  output logic                        tbl_hit,
  output logic                        accept_comb
);

  logic [ENTRIES-1:0] entry_hit;
  logic [PREFIX_W-1:0] addr_prefix;

  assign addr_prefix = addr[ADDR_W-1 -: PREFIX_W];

  for (genvar n = 0; n < ENTRIES; n++) begin : g_cmp
    logic [PREFIX_W-1:0] entry;
    assign entry        = tbl[n*PREFIX_W +: PREFIX_W];
    assign entry_hit[n] = (entry != '0) && (prefix_from_entry(entry) == addr_prefix);
  end

  assign station_hit = addr == station_from_regs(station_hi, station_lo);
  assign bcast_hit   = all_ones(addr);
  assign group_hit   = group_bit(addr);
  assign tbl_hit     = group_hit && (|entry_hit);

  assign accept_comb = mode.promisc || station_hit || bcast_hit ||
                       (group_hit && mode.allmulti) || tbl_hit;

endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rdf_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int SEL_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [31:0]      cfg_wdata,
  input  logic             da_valid,
  input  logic             da_first,
  input  logic [7:0]       da_byte,
  output logic             dec_done,
  output logic             dec_accept
);

  logic [ADDR_W-1:0]           addr_full;
  logic                        last_byte;
  logic [15:0]                 station_hi;
  logic [31:0]                 station_lo;
  mode_t                       mode;
  logic [ENTRIES*PREFIX_W-1:0] tbl;
  logic                        station_hit;
  logic                        bcast_hit;
  logic                        group_hit;
  logic                        tbl_hit;
  logic                        accept_comb;
  logic                        mode_promisc;
  logic                        mode_allmulti;

  assign mode_promisc  = mode.promisc;
  assign mode_allmulti = mode.allmulti;

  rdf_collect #(.OCTETS(ADDR_OCTETS)) collect_i (
    .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da_first(da_first),
    .da_byte(da_byte), .addr_full(addr_full), .last_byte(last_byte)
  );

  rdf_cfg #(.ENTRIES(ENTRIES), .SEL_W(SEL_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .station_hi(station_hi), .station_lo(station_lo),
    .mode(mode), .tbl(tbl)
  );

  rdf_match #(.ENTRIES(ENTRIES)) match_i (
    .addr(addr_full), .station_hi(station_hi), .station_lo(station_lo),
    .mode(mode), .tbl(tbl), .station_hit(station_hit), .bcast_hit(bcast_hit),
    .group_hit(group_hit), .tbl_hit(tbl_hit), .accept_comb(accept_comb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_done   <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_done   <= last_byte;
      dec_accept <= last_byte && accept_comb;
    end
  end

endmodule

// File: rtl/rdf_checker.sv
module rdf_checker (
  input logic clk,
  input logic rst_n,
  input logic last_byte,
  input logic mode_promisc,
  input logic mode_allmulti,
  input logic station_hit,
  input logic bcast_hit,
  input logic group_hit,
  input logic tbl_hit,
  input logic dec_done,
  input logic dec_accept
);

  // R2
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte |=> dec_done);

  // R2
  done_only_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !last_byte |=> !dec_done);

  // R3
  station_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte && station_hit) |=> dec_accept);

  // R4
  bcast_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte && bcast_hit) |=> dec_accept);

  // R5
  promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte && mode_promisc) |=> dec_accept);

  // R6
  allmulti_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte && mode_allmulti && group_hit) |=> dec_accept);

  // R7
  table_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte && tbl_hit) |=> dec_accept);

  // R7
  table_group_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_hit |-> group_hit);

  // R9
  unicast_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte && !group_hit && !mode_promisc && !station_hit && !bcast_hit)
      |=> !dec_accept);

  // R10
  accept_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_done |-> !dec_accept);

endmodule

bind rx_dest_filter rdf_checker chk_i (
  .clk(clk), .rst_n(rst_n), .last_byte(last_byte),
  .mode_promisc(mode_promisc), .mode_allmulti(mode_allmulti),
  .station_hit(station_hit), .bcast_hit(bcast_hit), .group_hit(group_hit),
  .tbl_hit(tbl_hit), .dec_done(dec_done), .dec_accept(dec_accept)
);

// File: tb/rx_dest_filter_tb_top.sv
module rx_dest_filter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        da_valid = 1'b0;
  logic        da_first = 1'b0;
  logic [7:0]  da_byte = '0;
  logic        dec_done;
  logic        dec_accept;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rx_dest_filter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .da_valid(da_valid), .da_first(da_first),
    .da_byte(da_byte), .dec_done(dec_done), .dec_accept(dec_accept)
  );

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic put(input logic [7:0] b, input logic first);
    @(negedge clk);
    da_valid = 1'b1; da_first = first; da_byte = b;
  endtask

  // Sends six octets, checks the decision one cycle later and the idle after.
  task automatic send_da(input logic [47:0] da, input logic exp, input string req);
    for (int i = 0; i < 6; i++) put(da[47-8*i -: 8], i == 0);
    @(negedge clk);
    da_valid = 1'b0; da_first = 1'b0;
    chk(dec_done, 1'b1, "R2", {req, " done strobe"});
    chk(dec_accept, exp, req, "accept");
    @(negedge clk);
    chk(dec_done, 1'b0, "R2", {req, " done one cycle only"});
    chk(dec_accept, 1'b0, "R10", {req, " accept low after done"});
  endtask

  task automatic t_reset;
    chk(dec_done, 1'b0, "R1", "done after reset");
    chk(dec_accept, 1'b0, "R1", "accept after reset");
    send_da(48'h00_00_00_00_00_00, 1'b1, "R1");
    send_da(48'h01_00_00_00_00_00, 1'b0, "R1");
  endtask

  task automatic t_station;
    wr(3'd0, 32'h0000_0211);
    wr(3'd1, 32'h2233_4455);
    send_da(48'h02_11_22_33_44_55, 1'b1, "R3");
    send_da(48'h02_11_22_33_44_56, 1'b0, "R9");
    send_da(48'h00_00_00_00_00_00, 1'b0, "R9");
    wr(3'd3, 32'hFFFF_FFFF);
    send_da(48'h02_11_22_33_44_55, 1'b1, "R3");
  endtask

  task automatic t_bcast;
    send_da(48'hFF_FF_FF_FF_FF_FF, 1'b1, "R4");
  endtask

  task automatic t_table;
    wr(3'd4, 32'h005E_0001);
    send_da(48'h01_00_5E_7F_00_01, 1'b1, "R7");
    send_da(48'h01_00_5E_00_AB_CD, 1'b1, "R7");
    send_da(48'h01_00_5F_7F_00_01, 1'b0, "R9");
    wr(3'd7, 32'h0033_2233);
    send_da(48'h33_22_33_00_00_01, 1'b1, "R7");
    wr(3'd4, 32'h0);
    send_da(48'h01_00_5E_7F_00_01, 1'b0, "R8");
  endtask

  task automatic t_zero;
    send_da(48'h00_00_00_11_22_33, 1'b0, "R8");
  endtask

  task automatic t_allmulti;
    wr(3'd2, 32'h2);
    send_da(48'h01_80_C2_00_00_00, 1'b1, "R6");
    send_da(48'h04_80_C2_00_00_00, 1'b0, "R6");
    wr(3'd2, 32'h0);
    send_da(48'h01_80_C2_00_00_00, 1'b0, "R9");
  endtask

  task automatic t_promisc;
    wr(3'd2, 32'h1);
    send_da(48'h0A_BC_DE_F0_12_34, 1'b1, "R5");
    send_da(48'h07_00_00_00_00_09, 1'b1, "R5");
    wr(3'd2, 32'h0);
    send_da(48'h0A_BC_DE_F0_12_34, 1'b0, "R9");
  endtask

  task automatic t_timing;
    logic seen;
    // Gaps between octets, then two trailing octets.
    for (int i = 0; i < 6; i++) begin
      put(8'hFF, i == 0);
      @(negedge clk);
      da_valid = 1'b0;
      if (i < 5) chk(dec_done, 1'b0, "R2", "no done before sixth octet");
    end
    chk(dec_done, 1'b1, "R2", "done after gapped sixth octet");
    chk(dec_accept, 1'b1, "R4", "gapped broadcast");
    seen = 1'b0;
    put(8'hFF, 1'b0);
    put(8'hFF, 1'b0);
    @(negedge clk);
    da_valid = 1'b0;
    seen = dec_done;
    @(negedge clk);
    seen = seen | dec_done;
    chk(seen, 1'b0, "R2", "trailing octets ignored");
    // Octets without a first marker are ignored.
    for (int i = 0; i < 7; i++) put(8'hFF, 1'b0);
    @(negedge clk);
    da_valid = 1'b0;
    chk(dec_done, 1'b0, "R2", "no done without first marker");
    // Restart in mid-address: three octets, then a full station address.
    put(8'hFF, 1'b1);
    put(8'hFF, 1'b0);
    put(8'hFF, 1'b0);
    send_da(48'h02_11_22_33_44_55, 1'b1, "R3");
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_station;
    t_bcast;
    t_table;
    t_zero;
    t_allmulti;
    t_promisc;
    t_timing;
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule